// File: doc/BRIEF.md
# Windowed Dual-Port Page Translation Map

This block holds the page translation table of a shared local bus. Every cycle its translation port takes a bus virtual address, looks up the entry for that virtual page and returns the real address one clock later. The real page number comes from the entry and the page offset passes through unchanged. The block's other port is a register-style access port. It lets any bus master read or write the table as 16-bit words while translations go on in parallel.

Each 32-bit entry is stored as two 16-bit halves that sit apart inside a 16-byte stride. The table can be reached through two views. In the map space, every entry is addressed directly. In the peripheral space there is a narrow window onto the table. The low index bits come from the access address and the high index bits come from a single shared write-only window register. Masters whose address space is too small for the whole table use this window. Masters with a large address space may use either view.

The defaults (10 index bits, a 7-bit window) keep the storage small. The full-size table uses `IDX_W = 16` and `WIN_W = 11`: a 2048-entry window and 5 window-register bits.

Top module: `pmap_top`

## Requirements
- R1: `xl_paddr` in the cycle after `xl_vaddr` is presented equals {entry[31:0], `xl_vaddr[12:0]`}. The entry is selected by `xl_vaddr[IDX_W+12:13]`, and the 13-bit page offset passes through untranslated.
- R2: With `reg_space`=1 (map space), byte address idx*16+6 reaches the entry's high half (bits 31:16) and idx*16+14 reaches its low half (bits 15:0). A write takes `reg_wdata`. A read returns the stored half on `reg_rdata` one cycle after the request.
- R3: With `reg_space`=0 (peripheral space), byte address 0x8000+w*16+{6,14} reaches entry {window register, w}, where w has WIN_W bits, with the same half layout as R2.
- R4: The window register sits at peripheral byte address 0x4407. A write loads `reg_wdata[IDX_W-WIN_W-1:0]`. A read of that address returns zero.
- R5: An access at any stride offset other than 6 or 14 reads as zero and writes nothing, in either space.
- R6: When a register write and a translation target the same entry in the same cycle, the translation returns the old value. A translation of that entry one cycle later returns the new value.
- R7: After reset the window register is zero, and `reg_rdata` is zero in any cycle that does not follow a decoded read.
- R8: Peripheral addresses outside the window and the window register read as zero, and writes to them change no entry.
- R9: Translations run every cycle regardless of register-port traffic and return correct values while register reads and writes proceed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xl_vaddr | input | IDX_W+13 | Virtual address to translate |
| xl_paddr | output | 45 | Real address (32-bit page number, 13-bit offset), one cycle later |
| reg_en | input | 1 | Register-port access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_space | input | 1 | 1 = map space (unfolded), 0 = peripheral space |
| reg_addr | input | max(16, IDX_W+4) | Byte address within the selected space |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, one cycle after a read |

## Verification
The bench tests a write and a translation that hit the same entry in one cycle. A design that forwarded the new value, or that delayed the update by an extra cycle, would return the wrong real page. It writes through the window after changing the window register. A design that ignored the register, or took the wrong index bits, would corrupt a different entry, and a read through the direct view would expose that. Stray stride offsets and unmapped peripheral addresses are written with marker values and the neighbouring halves are read back. A design with a loose offset decode would overwrite a real half or return nonzero data. Reads of the write-only window register must come back as zero.

// File: rtl/pm_pkg.sv
package pm_pkg;
   typedef enum logic [1:0] {HALF_NONE = 2'd0, HALF_HI = 2'd1, HALF_LO = 2'd2} half_e;

   localparam logic [3:0]  OFS_HI       = 4'h6;
   localparam logic [3:0]  OFS_LO       = 4'hE;
   localparam logic [15:0] WINREG_OFS   = 16'h4407;

   function automatic half_e stride_half(input logic [3:0] ofs);
      if (ofs == OFS_HI)      return HALF_HI;
      else if (ofs == OFS_LO) return HALF_LO;
      else                    return HALF_NONE;
   endfunction
endpackage

// File: rtl/pm_winreg.sv
module pm_winreg #(
   parameter int HI_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [HI_W-1:0] d,
   output logic [HI_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end

   // R4: the window bits change only on a decoded write to the register
   p_winreg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
endmodule

// File: rtl/pm_decode.sv
module pm_decode import pm_pkg::*; #(
   parameter int IDX_W = 10,
   parameter int WIN_W = 7,
   parameter int RA_W  = 16
) (
   input  logic                   reg_en,
   input  logic                   reg_we,
   input  logic                   reg_space,
   input  logic [RA_W-1:0]        reg_addr,
   input  logic [IDX_W-WIN_W-1:0] win_hi,
   output logic                   acc_hit,
   output half_e                  acc_half,
   output logic [IDX_W-1:0]       acc_idx,
   output logic                   winreg_we
);
   logic map_top_ok, win_top_ok, win_mid_ok, sel_ok;

   if (RA_W > IDX_W + 4) begin : g_map_top
      assign map_top_ok = ~|reg_addr[RA_W-1:IDX_W+4];
   end else begin : g_map_full
      assign map_top_ok = 1'b1;
   end

   if (RA_W > 16) begin : g_win_top
      assign win_top_ok = ~|reg_addr[RA_W-1:16];
   end else begin : g_win_flat
      assign win_top_ok = 1'b1;
   end

   if (WIN_W < 11) begin : g_win_mid
      assign win_mid_ok = ~|reg_addr[14:WIN_W+4];
   end else begin : g_win_full
      assign win_mid_ok = 1'b1;
   end

   assign acc_half = stride_half(reg_addr[3:0]);

   always_comb begin
      if (reg_space) begin
         acc_idx = reg_addr[IDX_W+3:4];
         sel_ok  = map_top_ok;
      end else begin
         acc_idx = {win_hi, reg_addr[WIN_W+3:4]};
         sel_ok  = reg_addr[15] && win_top_ok && win_mid_ok;
      end
   end

   assign acc_hit   = reg_en && sel_ok && (acc_half != HALF_NONE);
   assign winreg_we = reg_en && reg_we && !reg_space
                      && (reg_addr == RA_W'(WINREG_OFS));
endmodule

// File: rtl/pm_store.sv
module pm_store #(
   parameter int IDX_W = 10,
   parameter int DW    = 16,
   parameter int NBANK = 2
) (
   input  logic                       clk,
   input  logic [NBANK-1:0]           wr_en,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [DW-1:0]              wr_data,
   input  logic [IDX_W-1:0]           rd_idx,
   output logic [NBANK-1:0][DW-1:0]   rd_q,
   input  logic [IDX_W-1:0]           xl_idx,
   output logic [NBANK-1:0][DW-1:0]   xl_q
);
   localparam int DEPTH = 1 << IDX_W;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [DW-1:0] mem [DEPTH];
      logic [DW-1:0] rd_r, xl_r;

      // reads see the pre-write contents (old value on collision)
      always_ff @(posedge clk) begin
         if (wr_en[b]) mem[wr_idx] <= wr_data;
         rd_r <= mem[rd_idx];
         xl_r <= mem[xl_idx];
      end

      assign rd_q[b] = rd_r;
      assign xl_q[b] = xl_r;
   end
endmodule

// File: rtl/pmap_top.sv
module pmap_top import pm_pkg::*; #(
   parameter  int IDX_W  = 10,
   parameter  int WIN_W  = 7,
   parameter  int PAGE_W = 13,
   localparam int HI_W   = IDX_W - WIN_W,
   localparam int VA_W   = PAGE_W + IDX_W,
   localparam int PA_W   = PAGE_W + 32,
   localparam int RA_W   = (IDX_W + 4 > 16) ? IDX_W + 4 : 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [VA_W-1:0] xl_vaddr,
   output logic [PA_W-1:0] xl_paddr,
   input  logic            reg_en,
   input  logic            reg_we,
   input  logic            reg_space,
   input  logic [RA_W-1:0] reg_addr,
   input  logic [15:0]     reg_wdata,
   output logic [15:0]     reg_rdata
);
   if (WIN_W > 11 || WIN_W < 1) begin : g_bad_win
      $error("pmap_top: WIN_W must lie in 1..11");
   end
   if (HI_W < 1) begin : g_bad_hi
      $error("pmap_top: IDX_W must exceed WIN_W");
   end
   if (PAGE_W < 4) begin : g_bad_page
      $error("pmap_top: PAGE_W too small");
   end

   logic [HI_W-1:0]        win_hi;
   logic                   acc_hit, winreg_we;
   half_e                  acc_half;
   logic [IDX_W-1:0]       acc_idx;
   logic [1:0]             bank_we;
   logic [1:0][15:0]       rd_q, xl_q;
   logic                   rd_pend;
   half_e                  half_q;
   logic [PAGE_W-1:0]      off_q;

   pm_decode #(.IDX_W(IDX_W), .WIN_W(WIN_W), .RA_W(RA_W)) u_dec (
      .reg_en(reg_en), .reg_we(reg_we), .reg_space(reg_space),
      .reg_addr(reg_addr), .win_hi(win_hi), .acc_hit(acc_hit),
      .acc_half(acc_half), .acc_idx(acc_idx), .winreg_we(winreg_we));

   pm_winreg #(.HI_W(HI_W)) u_win (
      .clk(clk), .rst_n(rst_n), .we(winreg_we),
      .d(reg_wdata[HI_W-1:0]), .q(win_hi));

   // bank 1 holds the high half, bank 0 the low half
   assign bank_we[1] = acc_hit && reg_we && (acc_half == HALF_HI);
   assign bank_we[0] = acc_hit && reg_we && (acc_half == HALF_LO);

   pm_store #(.IDX_W(IDX_W), .DW(16), .NBANK(2)) u_store (
      .clk(clk), .wr_en(bank_we), .wr_idx(acc_idx), .wr_data(reg_wdata),
      .rd_idx(acc_idx), .rd_q(rd_q),
      .xl_idx(xl_vaddr[VA_W-1:PAGE_W]), .xl_q(xl_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_pend <= 1'b0;
         half_q  <= HALF_NONE;
      end else begin
         rd_pend <= acc_hit && !reg_we;
         half_q  <= acc_half;
      end
   end

   always_ff @(posedge clk) off_q <= xl_vaddr[PAGE_W-1:0];

   assign reg_rdata = !rd_pend ? 16'h0 : (half_q == HALF_HI) ? rd_q[1] : rd_q[0];
   assign xl_paddr  = {xl_q[1], xl_q[0], off_q};

   // R1: page offset is carried through one cycle later
   p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      xl_paddr[PAGE_W-1:0] == $past(xl_vaddr[PAGE_W-1:0]));

   // R4: reading the write-only window register yields zero
   p_winreg_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_en && !reg_we && !reg_space && reg_addr == RA_W'(WINREG_OFS))
      |=> reg_rdata == 16'h0);

   // R5 / R8: undecoded reads return zero
   p_stray_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_en && !reg_we && !acc_hit) |=> reg_rdata == 16'h0);

   // R7: idle register port gives zero data on the next cycle
   p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_en |=> reg_rdata == 16'h0);
endmodule

// File: tb/pmap_top_tb.sv
module pmap_top_tb;
   localparam int CLK_PERIOD = 10;
   localparam int IDX_W  = 10;
   localparam int WIN_W  = 7;
   localparam int PAGE_W = 13;
   localparam int HI_W   = IDX_W - WIN_W;
   localparam int DEPTH  = 1 << IDX_W;
   localparam int VA_W   = PAGE_W + IDX_W;
   localparam int PA_W   = PAGE_W + 32;
   localparam int RA_W   = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [VA_W-1:0] xl_vaddr = '0;
   logic [PA_W-1:0] xl_paddr;
   logic            reg_en = 1'b0, reg_we = 1'b0, reg_space = 1'b0;
   logic [RA_W-1:0] reg_addr = '0;
   logic [15:0]     reg_wdata = '0;
   logic [15:0]     reg_rdata;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   logic [31:0] mdl [DEPTH];
   bit          known [DEPTH];
   int          win = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmap_top #(.IDX_W(IDX_W), .WIN_W(WIN_W), .PAGE_W(PAGE_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .xl_vaddr(xl_vaddr), .xl_paddr(xl_paddr),
      .reg_en(reg_en), .reg_we(reg_we), .reg_space(reg_space),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

   // entry index and half (1 = high, 2 = low, 0 = none) for an access
   function automatic int map_idx(bit sp, int a, output int half);
      int o = a & 15;
      half = (o == 6) ? 1 : (o == 14) ? 2 : 0;
      if (sp) begin
         if (a < DEPTH * 16) return a >> 4;
      end else if (a >= 'h8000 && a < 'h8000 + (1 << WIN_W) * 16) begin
         return (win << WIN_W) | ((a - 'h8000) >> 4);
      end
      half = 0;
      return -1;
   endfunction

   function automatic logic [15:0] f_read(bit sp, int a);
      int h;
      int i = map_idx(sp, a, h);
      if (h == 1) return mdl[i][31:16];
      if (h == 2) return mdl[i][15:0];
      return 16'h0;
   endfunction

   task automatic f_write(bit sp, int a, logic [15:0] d);
      int h;
      int i = map_idx(sp, a, h);
      if (!sp && a == 'h4407) win = int'(d) & ((1 << HI_W) - 1);
      if (h == 1) mdl[i][31:16] = d;
      if (h == 2) mdl[i][15:0]  = d;
   endtask

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one cycle: drive, clock, check both ports, then update the model
   task automatic step(bit en, bit we, bit sp, int a, logic [15:0] wd,
                       int va, string req);
      logic [15:0]     e_rd;
      logic [PA_W-1:0] e_pa;
      int              pg = (va >> PAGE_W) & (DEPTH - 1);
      bit              xl_ok = known[pg];
      e_rd = (en && !we) ? f_read(sp, a) : 16'h0;
      e_pa = {mdl[pg], va[PAGE_W-1:0]};
      @(negedge clk);
      reg_en = en; reg_we = we; reg_space = sp;
      reg_addr = a[RA_W-1:0]; reg_wdata = wd; xl_vaddr = va[VA_W-1:0];
      @(posedge clk); #1;
      chk(reg_rdata == e_rd, req, 64'(reg_rdata), 64'(e_rd));
      if (xl_ok) chk(xl_paddr == e_pa, "R1/R9", 64'(xl_paddr), 64'(e_pa));
      if (en && we) begin
         int h;
         int i = map_idx(sp, a, h);
         f_write(sp, a, wd);
         if (h != 0) known[i] = 1'b1;
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5eed_0042);
      foreach (mdl[i]) begin mdl[i] = '0; known[i] = 1'b0; end
      repeat (3) @(posedge clk);
      #1 chk(reg_rdata == 16'h0, "R7 reset rdata", 64'(reg_rdata), 64'h0);
      @(negedge clk) rst_n = 1'b1;

      // R7: window register starts at zero, folded write lands on entry 5
      step(1, 1, 0, 'h8000 + 5*16 + 6, 16'hBEEF, 0, "R3");
      step(1, 0, 1, 5*16 + 6, 16'h0, 0, "R7 window reset value");
      step(0, 0, 0, 0, 16'h0, 0, "R7 idle");

      // R2: fill every entry through the map space
      for (int i = 0; i < DEPTH; i++) begin
         step(1, 1, 1, i*16 + 6,  16'($urandom), 0, "R2");
         step(1, 1, 1, i*16 + 14, 16'($urandom), 0, "R2");
      end
      step(1, 0, 1, 37*16 + 14, 16'h0, 0, "R2 read low");
      step(1, 0, 1, 37*16 + 6,  16'h0, 0, "R2 read high");

      // R4: set window, access through it, read back via map space
      step(1, 1, 0, 'h4407, 16'h0003, 0, "R4");
      step(1, 1, 0, 'h8000 + 9*16 + 14, 16'h1234, 0, "R3");
      step(1, 0, 1, ((3 << WIN_W) | 9)*16 + 14, 16'h0, 0, "R3 folded index");
      step(1, 0, 0, 'h4407, 16'h0, 0, "R4 write-only reads zero");

      // R5: stray stride offsets
      step(1, 1, 1, 7*16 + 2,  16'hDEAD, 0, "R5");
      step(1, 1, 0, 'h8000 + 7*16 + 8, 16'hDEAD, 0, "R5");
      step(1, 0, 1, 7*16 + 2,  16'h0, 0, "R5 stray read");
      step(1, 0, 1, 7*16 + 6,  16'h0, 0, "R5 neighbour high");
      step(1, 0, 1, ((3 << WIN_W) | 7)*16 + 14, 16'h0, 0, "R5 neighbour low");

      // R8: undecoded peripheral addresses
      step(1, 1, 0, 'h1236, 16'hCAFE, 0, "R8");
      step(1, 0, 0, 'h1236, 16'h0, 0, "R8 unmapped read");
      step(1, 1, 0, 'h8000 + (1 << WIN_W)*16 + 6, 16'hCAFE, 0, "R8");
      step(1, 0, 0, 'h8000 + (1 << WIN_W)*16 + 6, 16'h0, 0, "R8 past window");
      step(1, 0, 1, 0*16 + 6, 16'h0, 0, "R8 entry 0 untouched");

      // R6: write and translate the same entry in one cycle, then again
      step(1, 1, 1, 9*16 + 6, 16'hA5A5, (9 << PAGE_W) | 'h123, "R6 old value");
      step(0, 0, 0, 0, 16'h0, (9 << PAGE_W) | 'h0AB, "R6 new value");

      // R9: random traffic on both ports
      for (int n = 0; n < 4000; n++) begin
         int r  = int'($urandom_range(0, 9));
         int va = int'($urandom) & ((1 << VA_W) - 1);
         int a;
         bit sp = (r < 5);
         if (sp) a = int'($urandom_range(0, DEPTH*16 - 1)) & ~9;
         else if (r == 9) a = 'h4407;
         else a = ('h8000 + int'($urandom_range(0, (1 << WIN_W)*16 - 1))) & ~9;
         if ((n & 7) == 0) a = int'($urandom) & 'hFFFF;
         step(1, $urandom_range(0, 1) == 1, sp, a, 16'($urandom), va, "R9");
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule